// File: doc/BRIEF.md
# Boot Mode Fetch Router

This block sits between a processor core and its boot sources. When the core fetches instruction words after reset, the router sends each fetch to one of four sources: a word-wide local flash, a byte-wide local flash, or one of two fixed windows on a PCI-side master port. A 2-bit strap input picks the source.

The strap is captured while reset is held and is frozen once reset is released. Software can read the captured value in a 2-bit field of a control word. The rest of that word reads as zero here, because other logic owns those bits.

For the PCI sources, the boot address is moved into a fixed PCI window by wiring alone, with no programmable translation registers. A fetch that lies outside the active window gets an error response and is never forwarded. For the byte-wide flash, one core fetch becomes four byte reads, which are packed into one word.

Every response carries a cacheable attribute: set for the flash sources, clear for the PCI sources. Only one fetch is in flight at a time.

Top module: `boot_fetch_router`

## Requirements
- R1: The strap `boot_sel` is captured while `rst_n` is low and held until the next reset; later changes have no effect. `ctrl_rd_data[22:21]` shows the captured code and all other bits read 0. Codes are: 00 word flash, 01 byte flash, 10 PCI window A, 11 PCI window B.
- R2: In mode 00, a fetch causes exactly one flash read with `fl_req_byte`=0 at the address with bits 1:0 cleared. The returned 32-bit word is passed to `rsp_data` unchanged.
- R3: In mode 01, a fetch causes four flash reads with `fl_req_byte`=1, at the word-aligned address plus 0, 1, 2 and 3, in that order. Only bits 7:0 of each returned value are used. The byte at offset 0 lands in `rsp_data[31:24]` and the byte at offset 3 in bits 7:0. The response appears only after the fourth byte has returned.
- R4: In mode 10, a fetch with address below 0x0100_0000 is sent on the PCI port to address 0xF0 followed by the low 24 address bits, with bits 1:0 cleared. The PCI read data is returned unchanged.
- R5: In mode 11, a fetch with address below 0x0001_0000 is sent on the PCI port to address 0x7FFF followed by the low 16 address bits, with bits 1:0 cleared.
- R6: In mode 10 or 11, a fetch outside the active window gets a response with `rsp_err`=1 and `rsp_data`=0. It issues no request on either port.
- R7: `req_ready` is high only when the block is idle. It is low from the cycle after a fetch is accepted through the response cycle, so only one fetch is ever in flight.
- R8: `rsp_valid` is a single-cycle pulse. `rsp_cacheable` is 1 in modes 00 and 01 and 0 in modes 10 and 11. The flash port is never requested in the PCI modes, and the PCI port is never requested in the flash modes.
- R9: A port request (valid and address) stays asserted and unchanged while the port's ready input is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; strap is captured while low |
| boot_sel | input | 2 | Boot source strap |
| req_valid | input | 1 | Core fetch request valid |
| req_addr | input | 32 | Core fetch byte address |
| req_ready | output | 1 | Block idle and accepting a fetch |
| rsp_valid | output | 1 | Fetch response pulse |
| rsp_data | output | 32 | Fetched word |
| rsp_err | output | 1 | Fetch fell outside the PCI window |
| rsp_cacheable | output | 1 | Cacheable attribute of the fetch |
| fl_req_valid | output | 1 | Flash read request valid |
| fl_req_addr | output | 32 | Flash read address |
| fl_req_byte | output | 1 | Flash read is a single byte |
| fl_req_ready | input | 1 | Flash accepts the request |
| fl_rsp_valid | input | 1 | Flash read data valid |
| fl_rsp_data | input | 32 | Flash read data |
| pci_req_valid | output | 1 | PCI read request valid |
| pci_req_addr | output | 32 | Remapped PCI address |
| pci_req_ready | input | 1 | PCI master accepts the request |
| pci_rsp_valid | input | 1 | PCI read data valid |
| pci_rsp_data | input | 32 | PCI read data |
| ctrl_rd_data | output | 32 | Control word with the strap at bits 22:21 |

## Verification
The bench builds the block with its default parameters: the strap field at bit 21, an 8-bit 0xF0 prefix for window A and a 16-bit 0x7FFF prefix for window B. With these values, addresses on both sides of each window edge can be reached with ordinary constants, so both the in-window remap and the error path are exercised in each PCI mode. Its flash and PCI models return data derived from the address they receive, so a wrong remap or a wrong byte order shows up as wrong data. Holding a port's ready input low lets the bench observe the stall and the single-outstanding behaviour.

// File: rtl/boot_fetch_router.sv
module boot_fetch_router #(
  parameter int unsigned SEL_LSB = 21,
  parameter int unsigned WA_PFX_W = 8,
  parameter logic [WA_PFX_W-1:0] WA_PFX = 8'hF0,
  parameter int unsigned WB_PFX_W = 16,
  parameter logic [WB_PFX_W-1:0] WB_PFX = 16'h7FFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  boot_sel,
  input  logic        req_valid,
  input  logic [31:0] req_addr,
  output logic        req_ready,
  output logic        rsp_valid,
  output logic [31:0] rsp_data,
  output logic        rsp_err,
  output logic        rsp_cacheable,
  output logic        fl_req_valid,
  output logic [31:0] fl_req_addr,
  output logic        fl_req_byte,
  input  logic        fl_req_ready,
  input  logic        fl_rsp_valid,
  input  logic [31:0] fl_rsp_data,
  output logic        pci_req_valid,
  output logic [31:0] pci_req_addr,
  input  logic        pci_req_ready,
  input  logic        pci_rsp_valid,
  input  logic [31:0] pci_rsp_data,
  output logic [31:0] ctrl_rd_data
);
  localparam int unsigned WA_SPAN = 32 - WA_PFX_W;
  localparam int unsigned WB_SPAN = 32 - WB_PFX_W;

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_RESP} state_t;

  state_t      state;
  logic [1:0]  mode;
  logic [31:0] addr_q;
  logic [31:0] data_q;
  logic [1:0]  beat;
  logic        err_q;

  wire to_pci    = mode[1];
  wire byte_mode = (mode == 2'b01);
  wire in_win    = (mode == 2'b10) ? (req_addr[31:WA_SPAN] == '0)
                                   : (req_addr[31:WB_SPAN] == '0);
  wire reject    = to_pci && !in_win;
  wire port_rdy  = to_pci ? pci_req_ready : fl_req_ready;
  wire port_rsp  = to_pci ? pci_rsp_valid : fl_rsp_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode   <= boot_sel;
      state  <= S_IDLE;
      addr_q <= '0;
      data_q <= '0;
      beat   <= '0;
      err_q  <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          addr_q <= {req_addr[31:2], 2'b00};
          data_q <= '0;
          beat   <= '0;
          err_q  <= reject;
          state  <= reject ? S_RESP : S_ISSUE;
        end
        S_ISSUE: if (port_rdy) state <= S_WAIT;
        S_WAIT: if (port_rsp) begin
          if (byte_mode) begin
            data_q <= {data_q[23:0], fl_rsp_data[7:0]};
            beat   <= beat + 2'd1;
            state  <= (beat == 2'd3) ? S_RESP : S_ISSUE;
          end else begin
            data_q <= to_pci ? pci_rsp_data : fl_rsp_data;
            state  <= S_RESP;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign req_ready     = (state == S_IDLE);
  assign rsp_valid     = (state == S_RESP);
  assign rsp_data      = data_q;
  assign rsp_err       = err_q;
  assign rsp_cacheable = !to_pci;

  assign fl_req_valid  = (state == S_ISSUE) && !to_pci;
  assign fl_req_byte   = byte_mode;
  assign fl_req_addr   = byte_mode ? {addr_q[31:2], beat} : addr_q;

  assign pci_req_valid = (state == S_ISSUE) && to_pci;
  assign pci_req_addr  = (mode == 2'b10) ? {WA_PFX, addr_q[WA_SPAN-1:0]}
                                         : {WB_PFX, addr_q[WB_SPAN-1:0]};

  assign ctrl_rd_data  = 32'(mode) << SEL_LSB;
endmodule

// File: rtl/boot_fetch_router_chk.sv
module boot_fetch_router_chk #(
  parameter int unsigned SEL_LSB = 21
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        rsp_valid,
  input logic        rsp_cacheable,
  input logic        fl_req_valid,
  input logic        fl_req_ready,
  input logic [31:0] fl_req_addr,
  input logic        pci_req_valid,
  input logic        pci_req_ready,
  input logic [31:0] pci_req_addr,
  input logic [31:0] ctrl_rd_data
);
  wire pci_mode = ctrl_rd_data[SEL_LSB+1];

  a_r1_strap_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(ctrl_rd_data));

  a_r7_busy_on_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  a_r8_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  a_r8_attr: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_cacheable == !pci_mode));

  a_r8_no_flash_in_pci: assert property (@(posedge clk) disable iff (!rst_n)
    pci_mode |-> !fl_req_valid);

  a_r8_no_pci_in_flash: assert property (@(posedge clk) disable iff (!rst_n)
    !pci_mode |-> !pci_req_valid);

  a_r9_fl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_req_valid && !fl_req_ready) |=> (fl_req_valid && $stable(fl_req_addr)));

  a_r9_pci_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pci_req_valid && !pci_req_ready) |=> (pci_req_valid && $stable(pci_req_addr)));
endmodule

bind boot_fetch_router boot_fetch_router_chk #(.SEL_LSB(SEL_LSB)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rsp_cacheable(rsp_cacheable), .fl_req_valid(fl_req_valid),
  .fl_req_ready(fl_req_ready), .fl_req_addr(fl_req_addr),
  .pci_req_valid(pci_req_valid), .pci_req_ready(pci_req_ready),
  .pci_req_addr(pci_req_addr), .ctrl_rd_data(ctrl_rd_data)
);

// File: tb/boot_fetch_router_tb.sv
module boot_fetch_router_tb;
  logic clk = 0;
  always #2.5 clk = ~clk;

  logic        rst_n = 0;
  logic [1:0]  boot_sel = 0;
  logic        req_valid = 0;
  logic [31:0] req_addr = 0;
  logic        req_ready, rsp_valid, rsp_err, rsp_cacheable;
  logic [31:0] rsp_data, ctrl_rd_data;
  logic        fl_req_valid, fl_req_byte, pci_req_valid;
  logic [31:0] fl_req_addr, pci_req_addr;
  logic        fl_ready_en = 1, pci_ready_en = 1;
  logic        fl_rsp_valid = 0, pci_rsp_valid = 0;
  logic [31:0] fl_rsp_data = 0, pci_rsp_data = 0;
  logic [31:0] fl_log [0:7];
  logic [31:0] pci_log [0:7];
  logic        fl_byte_log [0:7];
  int          fl_cnt = 0, pci_cnt = 0;
  int          errors = 0, checks = 0;
  bit          done = 0;

  boot_fetch_router u_dut (
    .clk(clk), .rst_n(rst_n), .boot_sel(boot_sel),
    .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err),
    .rsp_cacheable(rsp_cacheable),
    .fl_req_valid(fl_req_valid), .fl_req_addr(fl_req_addr), .fl_req_byte(fl_req_byte),
    .fl_req_ready(fl_ready_en), .fl_rsp_valid(fl_rsp_valid), .fl_rsp_data(fl_rsp_data),
    .pci_req_valid(pci_req_valid), .pci_req_addr(pci_req_addr),
    .pci_req_ready(pci_ready_en), .pci_rsp_valid(pci_rsp_valid), .pci_rsp_data(pci_rsp_data),
    .ctrl_rd_data(ctrl_rd_data)
  );

  function automatic logic [31:0] fl_word(input logic [31:0] a);
    return a ^ 32'hC0DE_0000;
  endfunction
  function automatic logic [7:0] fl_b(input logic [31:0] a);
    return a[7:0] * 8'd7 + 8'h13;
  endfunction
  function automatic logic [31:0] pci_word(input logic [31:0] a);
    return a ^ 32'h0F0F_1234;
  endfunction

  always @(posedge clk) begin
    fl_rsp_valid <= 1'b0;
    if (fl_req_valid && fl_ready_en) begin
      fl_rsp_valid <= 1'b1;
      fl_rsp_data  <= fl_req_byte ? {24'hBAD_0FF, fl_b(fl_req_addr)} : fl_word(fl_req_addr);
      fl_log[fl_cnt[2:0]]      <= fl_req_addr;
      fl_byte_log[fl_cnt[2:0]] <= fl_req_byte;
      fl_cnt <= fl_cnt + 1;
    end
  end

  always @(posedge clk) begin
    pci_rsp_valid <= 1'b0;
    if (pci_req_valid && pci_ready_en) begin
      pci_rsp_valid <= 1'b1;
      pci_rsp_data  <= pci_word(pci_req_addr);
      pci_log[pci_cnt[2:0]] <= pci_req_addr;
      pci_cnt <= pci_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply_reset(input logic [1:0] sel);
    boot_sel = sel;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic launch(input logic [31:0] a);
    req_addr = a;
    req_valid = 1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wait_rsp(output logic [31:0] d, output logic e, output logic c);
    int n = 0;
    bit busy_ok = 1;
    while (!rsp_valid && n < 200) begin
      if (req_ready) busy_ok = 0;
      @(negedge clk);
      n++;
    end
    if (req_ready) busy_ok = 0;
    chk(rsp_valid, "R7 response arrives", 32'(rsp_valid), 1);
    chk(busy_ok, "R7 ready low while busy", 32'(busy_ok), 1);
    d = rsp_data; e = rsp_err; c = rsp_cacheable;
    @(negedge clk);
    chk(!rsp_valid && req_ready, "R8 single-cycle response", {30'd0, rsp_valid, req_ready}, 32'd1);
  endtask

  task automatic t_reset_state;
    apply_reset(2'b00);
    chk(ctrl_rd_data == 32'h0, "R1 ctrl after reset mode 00", ctrl_rd_data, 32'h0);
    chk(req_ready && !rsp_valid, "R7 idle after reset", {30'd0, req_ready, rsp_valid}, 32'd2);
  endtask

  task automatic t_word_flash;
    logic [31:0] d; logic e, c;
    int f0 = fl_cnt, p0 = pci_cnt;
    launch(32'h0000_1236);
    wait_rsp(d, e, c);
    chk(fl_cnt - f0 == 1, "R2 one flash read", 32'(fl_cnt - f0), 1);
    chk(fl_log[f0[2:0]] == 32'h0000_1234, "R2 aligned flash address", fl_log[f0[2:0]], 32'h0000_1234);
    chk(!fl_byte_log[f0[2:0]], "R2 word read flag", 32'(fl_byte_log[f0[2:0]]), 0);
    chk(d == fl_word(32'h1234) && !e, "R2 word data", d, fl_word(32'h1234));
    chk(c, "R8 cacheable in mode 00", 32'(c), 1);
    chk(pci_cnt == p0, "R8 no pci in flash mode", 32'(pci_cnt - p0), 0);
  endtask

  task automatic t_byte_flash;
    logic [31:0] d, exp; logic e, c;
    int f0;
    apply_reset(2'b01);
    chk(ctrl_rd_data == (32'd1 << 21), "R1 ctrl mode 01", ctrl_rd_data, 32'd1 << 21);
    boot_sel = 2'b11;
    repeat (3) @(negedge clk);
    chk(ctrl_rd_data == (32'd1 << 21), "R1 strap change ignored", ctrl_rd_data, 32'd1 << 21);
    f0 = fl_cnt;
    launch(32'h0000_0042);
    wait_rsp(d, e, c);
    chk(fl_cnt - f0 == 4, "R3 four byte reads", 32'(fl_cnt - f0), 4);
    for (int i = 0; i < 4; i++) begin
      int k = f0 + i;
      chk(fl_log[k[2:0]] == 32'h40 + 32'(i), "R3 byte address order", fl_log[k[2:0]], 32'h40 + 32'(i));
      chk(fl_byte_log[k[2:0]], "R3 byte flag", 32'(fl_byte_log[k[2:0]]), 1);
    end
    exp = {fl_b(32'h40), fl_b(32'h41), fl_b(32'h42), fl_b(32'h43)};
    chk(d == exp, "R3 big-endian packing", d, exp);
    chk(c && !e, "R8 cacheable in mode 01", {30'd0, c, e}, 32'd2);
  endtask

  task automatic t_pci_a;
    logic [31:0] d; logic e, c;
    int f0, p0;
    apply_reset(2'b10);
    chk(ctrl_rd_data == (32'd2 << 21), "R1 ctrl mode 10", ctrl_rd_data, 32'd2 << 21);
    f0 = fl_cnt; p0 = pci_cnt;
    launch(32'h00AB_CDE1);
    wait_rsp(d, e, c);
    chk(pci_log[p0[2:0]] == 32'hF0AB_CDE0, "R4 window A remap", pci_log[p0[2:0]], 32'hF0AB_CDE0);
    chk(d == pci_word(32'hF0AB_CDE0) && !e, "R4 pci data", d, pci_word(32'hF0AB_CDE0));
    chk(!c, "R8 non-cacheable in mode 10", 32'(c), 0);
    chk(fl_cnt == f0, "R8 no flash in pci mode", 32'(fl_cnt - f0), 0);
    p0 = pci_cnt;
    launch(32'h0100_0000);
    wait_rsp(d, e, c);
    chk(e && d == 0, "R6 window A outside -> error", {d[30:0], e}, 32'd1);
    chk(pci_cnt == p0 && fl_cnt == f0, "R6 no forward on error", 32'(pci_cnt - p0), 0);
  endtask

  task automatic t_pci_b;
    logic [31:0] d; logic e, c;
    int p0;
    apply_reset(2'b11);
    chk(ctrl_rd_data == (32'd3 << 21), "R1 ctrl mode 11", ctrl_rd_data, 32'd3 << 21);
    p0 = pci_cnt;
    launch(32'h0000_8004);
    wait_rsp(d, e, c);
    chk(pci_log[p0[2:0]] == 32'h7FFF_8004, "R5 window B remap", pci_log[p0[2:0]], 32'h7FFF_8004);
    chk(d == pci_word(32'h7FFF_8004) && !e && !c, "R5 pci data", d, pci_word(32'h7FFF_8004));
    launch(32'h0000_FFFE);
    wait_rsp(d, e, c);
    chk(pci_log[(p0 + 1) % 8] == 32'h7FFF_FFFC, "R5 window B top edge", pci_log[(p0 + 1) % 8], 32'h7FFF_FFFC);
    p0 = pci_cnt;
    launch(32'h0001_0000);
    wait_rsp(d, e, c);
    chk(e && pci_cnt == p0, "R6 window B outside -> error", 32'(e), 1);
  endtask

  task automatic t_stall;
    logic [31:0] d, a0; logic e, c;
    apply_reset(2'b00);
    fl_ready_en = 0;
    launch(32'h0000_0100);
    a0 = fl_req_addr;
    repeat (5) @(negedge clk);
    chk(fl_req_valid && fl_req_addr == a0 && a0 == 32'h100, "R9 request held while stalled", fl_req_addr, 32'h100);
    chk(!req_ready && !rsp_valid, "R7 busy while stalled", {30'd0, req_ready, rsp_valid}, 0);
    fl_ready_en = 1;
    wait_rsp(d, e, c);
    chk(d == fl_word(32'h100), "R9 data after stall", d, fl_word(32'h100));
  endtask

  initial begin
    t_reset_state();
    t_word_flash();
    t_byte_flash();
    t_pci_a();
    t_pci_b();
    t_stall();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule